// File: doc/BRIEF.md
# Roving-Checked Sparse Prefix Adder

This block is a 16-bit adder whose carries into the segment boundaries come from a parallel-prefix (Kogge-Stone style) carry network. Only the taps at bit positions 4, 8, 12 and 16 are used. Four 4-bit ripple segments then form the sum bits, each starting from the carry the network supplies for it. A fault-detection scheme checks one segment per clock cycle instead of triplicating the whole adder. Two shared ripple test adders, the same width as a segment, recompute the segment under test from that segment's operand bits and incoming carry. A bitwise 2-of-3 vote then chooses between the working segment and the two test copies.

A 2-bit selector chooses the segment under test and steps through 0, 1, 2, 3, then back to 0. Each cycle, the voted value replaces the tested segment's bits in the result. The other segments pass their own sums through unchanged. The result, the carry-out and the error flag are registered on the falling edge of the clock. The selector is registered on the rising edge.

When the vote finds a disagreement, the selector stops on that segment. It keeps substituting the corrected value until the disagreement goes away. A fault-injection input lets a test corrupt one chosen segment. Because of this, a fault in a segment that was just tested can reach the output for up to three cycles before it is caught.

Top module: `rove_sparse_adder`

## Requirements
- R1: With fault injection off, {cout, sum} captured at a falling edge equals a + b + cin as applied at that edge, for any operands.
- R2: While rst_n is low, sum, cout and err are 0 and the selector is 0. The first falling edge after release tests segment 0.
- R3: While err is low, the selector advances by one segment per rising edge and wraps from segment 3 to segment 0.
- R4: When the injected fault hits the segment under test, err is 1 in that cycle and {cout, sum} still equals a + b + cin.
- R5: When the injected fault hits a segment not under test, bit 4*k of sum is inverted for fault segment k, cout is unchanged, and err is 0.
- R6: While err is 1, the selector holds its segment. It resumes stepping in the first cycle in which the mismatch is gone.
- R7: fault_seg has no effect while fault_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; selector on rising edge, outputs on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| fault_en | input | 1 | Enables corruption of one working segment |
| fault_seg | input | 2 | Index of the segment to corrupt |
| sum | output | 16 | Registered sum |
| cout | output | 1 | Registered carry out of bit 15 |
| err | output | 1 | Registered mismatch flag of the current vote |

## Verification
On every cycle, the embedded assertions check four things: the arithmetic result whenever no fault is injected; the error flag and corrected result whenever the fault hits the tested segment; the selector holding on an error; and the selector stepping otherwise. Several behaviours can only be shown by the bench's scenarios. One is the exact number of cycles a latent fault escapes before the rover reaches it. Others are the wrap from segment 3 back to 0, the return to segment 0 after a mid-run reset, and the single flipped bit left in an untested segment.

// File: rtl/rove_sparse_adder.sv
module rove_sparse_adder #(
  parameter int SEG_W = 4,
  parameter int NSEG  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SEG_W*NSEG-1:0]     a,
  input  logic [SEG_W*NSEG-1:0]     b,
  input  logic                      cin,
  input  logic                      fault_en,
  input  logic [$clog2(NSEG)-1:0]   fault_seg,
  output logic [SEG_W*NSEG-1:0]     sum,
  output logic                      cout,
  output logic                      err
);
  localparam int W      = SEG_W * NSEG;
  localparam int SEL_W  = $clog2(NSEG);
  localparam int LEVELS = $clog2(W);
  localparam logic [SEG_W-1:0] FMASK = SEG_W'(1);

  function automatic logic [SEG_W-1:0] rca(input logic [SEG_W-1:0] x,
                                            input logic [SEG_W-1:0] y,
                                            input logic ci);
    logic [SEG_W-1:0] s;
    logic c;
    c = ci;
    for (int i = 0; i < SEG_W; i++) begin
      s[i] = x[i] ^ y[i] ^ c;
      c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
    end
    return s;
  endfunction

  logic [LEVELS:0][W-1:0] gk, pk;
  logic [NSEG-1:0]        segc;
  logic [W-1:0]           raw, merged;
  logic [SEL_W-1:0]       sel;
  logic [SEG_W-1:0]       opa, opb, wsum, t0, t1, vote;
  logic                   tci, mism;

  always_comb begin
    gk[0] = a & b;
    pk[0] = a ^ b;
    gk[0][0] = gk[0][0] | (pk[0][0] & cin);
    for (int l = 0; l < LEVELS; l++) begin
      for (int i = 0; i < W; i++) begin
        if (i >= (1 << l)) begin
          gk[l+1][i] = gk[l][i] | (pk[l][i] & gk[l][i-(1<<l)]);
          pk[l+1][i] = pk[l][i] & pk[l][i-(1<<l)];
        end else begin
          gk[l+1][i] = gk[l][i];
          pk[l+1][i] = pk[l][i];
        end
      end
    end
  end

  always_comb begin
    segc[0] = cin;
    for (int s = 1; s < NSEG; s++) segc[s] = gk[LEVELS][s*SEG_W-1];
  end

  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      raw[s*SEG_W +: SEG_W] = rca(a[s*SEG_W +: SEG_W], b[s*SEG_W +: SEG_W], segc[s])
                            ^ ((fault_en && fault_seg == SEL_W'(s)) ? FMASK : '0);
    end
  end

  assign opa  = a[sel*SEG_W +: SEG_W];
  assign opb  = b[sel*SEG_W +: SEG_W];
  assign tci  = segc[sel];
  assign wsum = raw[sel*SEG_W +: SEG_W];
  assign t0   = rca(opa, opb, tci);
  assign t1   = rca(opa, opb, tci);
  assign vote = (wsum & t0) | (wsum & t1) | (t0 & t1);
  assign mism = (wsum != t0) || (wsum != t1);

  always_comb begin
    merged = raw;
    merged[sel*SEG_W +: SEG_W] = vote;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      cout <= 1'b0;
      err  <= 1'b0;
    end else begin
      sum  <= merged;
      cout <= gk[LEVELS][W-1];
      err  <= mism;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel <= '0;
    else if (!err) sel <= sel + SEL_W'(1);
  end

  AST_CLEAN_SUM: assert property (@(negedge clk) disable iff (!rst_n)
    !fault_en |=> {cout, sum} == $past({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})); // R1
  AST_HIT_FLAG: assert property (@(negedge clk) disable iff (!rst_n)
    (fault_en && fault_seg == sel) |=> err); // R4
  AST_HIT_FIX: assert property (@(negedge clk) disable iff (!rst_n)
    (fault_en && fault_seg == sel) |=> {cout, sum} == $past({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})); // R4
  AST_MISS_QUIET: assert property (@(negedge clk) disable iff (!rst_n)
    (fault_en && fault_seg != sel) |=> !err); // R5
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(sel)); // R6
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !err |=> sel == $past(sel) + SEL_W'(1)); // R3
endmodule

// File: tb/tb_rove_sparse_adder.sv
module tb_rove_sparse_adder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  localparam logic [35:0] VEC [NV] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 2'd3},
    {16'hFFFF, 16'h0001, 1'b0, 1'b0, 2'd1},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 2'd2},
    {16'h0FFF, 16'h0000, 1'b1, 1'b0, 2'd0},
    {16'hAAAA, 16'h5555, 1'b1, 1'b0, 2'd3},
    {16'h1234, 16'h4321, 1'b0, 1'b0, 2'd2},
    {16'h00F0, 16'h0F10, 1'b0, 1'b0, 2'd1},
    {16'h7FFF, 16'h8000, 1'b1, 1'b0, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic cin = 1'b0, fault_en = 1'b0;
  logic [1:0] fault_seg = '0;
  logic [15:0] sum;
  logic cout, err;
  int checks = 0, failures = 0;
  int sel_m = 0;
  int rise_at;

  rove_sparse_adder dut (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
    .fault_en(fault_en), .fault_seg(fault_seg), .sum(sum), .cout(cout), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] ta, input logic [15:0] tb_, input logic tc,
                      input logic fe, input logic [1:0] fs, input string tag);
    logic [16:0] exp;
    logic exp_err;
    a = ta; b = tb_; cin = tc; fault_en = fe; fault_seg = fs;
    #7;
    exp = {1'b0, ta} + {1'b0, tb_} + {16'b0, tc};
    exp_err = fe && (int'(fs) == sel_m);
    if (fe && int'(fs) != sel_m) exp[int'(fs)*4] = ~exp[int'(fs)*4];
    chk({cout, sum} == exp, tag, {15'b0, cout, sum}, {15'b0, exp});
    chk(err == exp_err, tag, {31'b0, err}, {31'b0, exp_err});
    if (!exp_err) sel_m = (sel_m + 1) % 4;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #3;
    chk(sum == 16'h0 && !cout && !err, "R2 reset outputs", {15'b0, cout, sum}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    sel_m = 0;
    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      step(v[35:20], v[19:4], v[3], v[2], v[1:0], "R1 R7 vector");
    end
    // sel_m now 0 again (8 steps); latent fault on segment 2
    step(16'h0000, 16'h0000, 1'b0, 1'b1, 2'd2, "R5 escape");
    step(16'h0101, 16'h0001, 1'b0, 1'b1, 2'd2, "R5 escape");
    step(16'h1111, 16'h2222, 1'b0, 1'b1, 2'd2, "R4 caught");
    step(16'hFFFF, 16'h0001, 1'b0, 1'b1, 2'd2, "R6 frozen");
    step(16'h0F0F, 16'h0101, 1'b1, 1'b1, 2'd2, "R6 frozen");
    step(16'h4444, 16'h3333, 1'b0, 1'b0, 2'd2, "R6 release");
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0, "R3 advance");
    // mid-run reset while a fault is held
    step(16'h0000, 16'h0000, 1'b0, 1'b1, 2'd0, "R5 pre-reset");
    rst_n = 1'b0;
    #3;
    chk(sum == 16'h0 && !cout && !err, "R2 mid reset", {15'b0, cout, sum}, 32'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    sel_m = 0;
    // fault on segment 3 from reset: caught on the fourth cycle (R2, R3)
    rise_at = -1;
    for (int k = 0; k < 4; k++) begin
      a = 16'h0000; b = 16'h0000; cin = 1'b0; fault_en = 1'b1; fault_seg = 2'd3;
      #7;
      if (err && rise_at < 0) rise_at = k;
      @(posedge clk); #1;
    end
    chk(rise_at == 3, "R2 R3 first catch cycle", rise_at, 3);
    sel_m = 3;
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 2'd3, "R6 release");
    step(16'h0000, 16'h0000, 1'b0, 1'b1, 2'd0, "R3 wrap");
    step(16'h0000, 16'h0000, 1'b0, 1'b0, 2'd0, "R6 release");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule